// File: doc/BRIEF.md
# Clock Frequency Monitor with Hysteresis

This block qualifies one candidate reference clock against a free-running local clock. It raises two flags for the selection logic that sits above it. The loss-of-signal flag means the candidate has stopped toggling. The out-of-frequency flag means the candidate is toggling, but its rate is too far from nominal. A clock that raises either flag is disqualified.

The monitored clock's edges are counted in the monitored clock's own domain. At the end of every gate window, which lasts a fixed number of local cycles, a toggle handshake moves the count into the local domain. There the count is compared with a programmed nominal count. Tolerances are programmed as count limits, worked out ahead of time from the ppm figures: a tolerance of P ppm on a nominal count N is N·P/10⁶ counts. The raise limit and the lower limit are separate, so a deviation between them leaves the out-of-frequency flag as it was. Each monitored input has its own instance with its own limits.

Top module: `freq_mon`

## Requirements
- R1: While reset is high, and after reset until the second completed gate window, both `los_o` and `oof_o` read 1. The first window after reset is discarded as partial.
- R2: `los_o` rises once the monitored clock's activity bit (monitored edges divided by 2^(ACT_LOG2+1)) has been idle for `idle_limit_i` local cycles. A pause shorter than that limit sets neither flag.
- R3: `oof_o` reads 1 whenever `los_o` reads 1.
- R4: A window whose |count − `nominal_i`| is at least `raise_lim_i` sets `oof_o` to 1 while `los_o` stays 0. This holds for a clock running slow.
- R5: A window whose |count − `nominal_i`| is at most `lower_lim_i`, and below `raise_lim_i`, clears `oof_o`.
- R6: A window whose deviation lies strictly between the two limits leaves `oof_o` unchanged, whether it was 0 or 1.
- R7: When edges return after a loss of signal, `los_o` stays 1 through the window in which the clock restarts and through the next, partial window. It clears only when a full clean window has been measured.
- R8: The deviation is symmetric: a clock running fast by at least `raise_lim_i` counts sets `oof_o` in the same way as a slow one.
- R9: The flags change only in the cycle after a window result is taken in or after the idle detector fires. They hold steady between those events.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Free-running local clock; sets the gate window |
| rst_i | input | 1 | Synchronous active-high reset, local domain |
| mon_clk_i | input | 1 | Candidate clock under observation |
| nominal_i | input | 16 | Expected edge count per gate window |
| raise_lim_i | input | 16 | Deviation in counts at or above which `oof_o` sets |
| lower_lim_i | input | 16 | Deviation in counts at or below which `oof_o` clears |
| idle_limit_i | input | 16 | Local cycles without activity before `los_o` sets |
| los_o | output | 1 | Loss-of-signal flag |
| oof_o | output | 1 | Out-of-frequency flag |

## Verification
The checker watches the judging stage on every cycle. A result at or above the raise limit must set the flag, and a result at or below the lower limit must clear it. A band result must leave the flag alone, an idle timeout must set loss of signal, and loss of signal may fall only after an accepted measurement. Nothing may change between events. Only the bench scenarios show the end-to-end behaviour, because that depends on real clock rates and the handshake latency. These scenarios cover slow and fast clocks, band entries from both sides, a short pause, a full stop, and recovery that takes two windows.

// File: rtl/fmon_pkg.sv
package fmon_pkg;

    localparam int CNT_W = 16;
    localparam int LIM_W = 16;

    typedef logic [CNT_W-1:0] count_t;

    typedef enum logic [1:0] {
        JUDGE_HOLD  = 2'd0,
        JUDGE_RAISE = 2'd1,
        JUDGE_LOWER = 2'd2
    } judge_e;

    typedef struct packed {
        logic   done;
        count_t edges;
    } meas_t;

    function automatic count_t abs_gap(count_t a, count_t b);
        return (a >= b) ? (a - b) : (b - a);
    endfunction

    // Raise takes priority if the limits are programmed inverted.
    function automatic judge_e classify(count_t gap, count_t raise_lim, count_t lower_lim);
        if (gap >= raise_lim) return JUDGE_RAISE;
        if (gap <= lower_lim) return JUDGE_LOWER;
        return JUDGE_HOLD;
    endfunction

endpackage

// File: rtl/fmon_sync.sv
module fmon_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    always_ff @(posedge clk) begin
        if (rst) chain <= '0;
        else     chain <= {chain[STAGES-2:0], d};
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/fmon_mon_side.sv
module fmon_mon_side
    import fmon_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int ACT_LOG2    = 2
) (
    input  logic   mon_clk,
    input  logic   req_tgl,
    output logic   ack_tgl,
    output count_t snap,
    output logic   act_tgl
);
    logic            req_seen;
    logic [ACT_LOG2:0] div_q;
    count_t          run_q;

    // No reset in this domain: the clock may be absent while reset is high.
    fmon_sync #(.STAGES(SYNC_STAGES)) u_req_sync (
        .clk(mon_clk), .rst(1'b0), .d(req_tgl), .q(req_seen)
    );

    always_ff @(posedge mon_clk) begin
        div_q <= div_q + 1'b1;
        if (req_seen != ack_tgl) begin
            snap    <= run_q;
            run_q   <= count_t'(1);
            ack_tgl <= req_seen;
        end else if (run_q != '1) begin
            run_q <= run_q + 1'b1;
        end
    end

    assign act_tgl = div_q[ACT_LOG2];
endmodule

// File: rtl/fmon_gate.sv
module fmon_gate
    import fmon_pkg::*;
#(
    parameter int GATE_CYCLES = 1000,
    parameter int SYNC_STAGES = 2
) (
    input  logic   clk,
    input  logic   rst,
    input  logic   ack_tgl_async,
    input  count_t snap_async,
    output logic   req_tgl,
    output logic   issue,
    output meas_t  meas
);
    localparam int GW = (GATE_CYCLES > 1) ? $clog2(GATE_CYCLES) : 1;
    localparam logic [GW-1:0] LAST_TICK = GW'(GATE_CYCLES - 1);

    logic [GW-1:0] tick_q;
    logic          waiting_q;
    logic          ack_s;
    logic          win_end;

    fmon_sync #(.STAGES(SYNC_STAGES)) u_ack_sync (
        .clk(clk), .rst(rst), .d(ack_tgl_async), .q(ack_s)
    );

    assign win_end = (tick_q == LAST_TICK);

    always_ff @(posedge clk) begin
        if (rst) begin
            tick_q    <= '0;
            req_tgl   <= 1'b0;
            waiting_q <= 1'b0;
            issue     <= 1'b0;
            meas      <= '0;
        end else begin
            tick_q    <= win_end ? '0 : tick_q + 1'b1;
            issue     <= 1'b0;
            meas.done <= 1'b0;
            if (waiting_q) begin
                if (ack_s == req_tgl) begin
                    waiting_q  <= 1'b0;
                    meas.done  <= 1'b1;
                    meas.edges <= snap_async;
                end
            end else if (win_end) begin
                req_tgl   <= ~req_tgl;
                waiting_q <= 1'b1;
                issue     <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/fmon_idle.sv
module fmon_idle
    import fmon_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             act_async,
    input  logic [LIM_W-1:0] limit,
    output logic             starved
);
    logic             act_s;
    logic             act_d;
    logic [LIM_W-1:0] idle_q;

    fmon_sync #(.STAGES(SYNC_STAGES)) u_act_sync (
        .clk(clk), .rst(rst), .d(act_async), .q(act_s)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            act_d  <= 1'b0;
            idle_q <= '0;
        end else begin
            act_d <= act_s;
            if (act_s != act_d)  idle_q <= '0;
            else if (idle_q != '1) idle_q <= idle_q + 1'b1;
        end
    end

    assign starved = (idle_q >= limit);
endmodule

// File: rtl/fmon_judge.sv
module fmon_judge
    import fmon_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  meas_t  meas,
    input  logic   issue,
    input  logic   starved,
    input  count_t nominal,
    input  count_t raise_lim,
    input  count_t lower_lim,
    output logic   los,
    output logic   oof,
    output logic   eval_evt,
    output count_t gap
);
    logic   primed_q;
    logic   quiet_q;
    logic   los_q;
    logic   hyst_q;
    judge_e verdict;

    assign gap      = abs_gap(meas.edges, nominal);
    assign verdict  = classify(gap, raise_lim, lower_lim);
    assign eval_evt = meas.done && !starved && !quiet_q && primed_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            primed_q <= 1'b0;
            quiet_q  <= 1'b0;
            los_q    <= 1'b1;
            hyst_q   <= 1'b1;
        end else begin
            if (issue)        quiet_q <= starved;
            else if (starved) quiet_q <= 1'b1;

            if (starved) begin
                los_q    <= 1'b1;
                hyst_q   <= 1'b1;
                primed_q <= 1'b0;
            end else if (meas.done) begin
                if (quiet_q)        primed_q <= 1'b0;
                else if (!primed_q) primed_q <= 1'b1;
                else begin
                    los_q <= 1'b0;
                    case (verdict)
                        JUDGE_RAISE: hyst_q <= 1'b1;
                        JUDGE_LOWER: hyst_q <= 1'b0;
                        default:     hyst_q <= hyst_q;
                    endcase
                end
            end
        end
    end

    assign los = los_q;
    assign oof = hyst_q | los_q;
endmodule

// File: rtl/freq_mon.sv
module freq_mon
    import fmon_pkg::*;
#(
    parameter int GATE_CYCLES = 1000,
    parameter int SYNC_STAGES = 2,
    parameter int ACT_LOG2    = 2
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic             mon_clk_i,
    input  logic [CNT_W-1:0] nominal_i,
    input  logic [CNT_W-1:0] raise_lim_i,
    input  logic [CNT_W-1:0] lower_lim_i,
    input  logic [LIM_W-1:0] idle_limit_i,
    output logic             los_o,
    output logic             oof_o
);
    logic   req_tgl;
    logic   ack_tgl;
    logic   act_tgl;
    count_t snap;
    logic   issue;
    meas_t  meas;
    logic   starved;
    logic   eval_evt;
    count_t gap;

    fmon_mon_side #(.SYNC_STAGES(SYNC_STAGES), .ACT_LOG2(ACT_LOG2)) u_mon_side (
        .mon_clk(mon_clk_i), .req_tgl(req_tgl), .ack_tgl(ack_tgl),
        .snap(snap), .act_tgl(act_tgl)
    );

    fmon_gate #(.GATE_CYCLES(GATE_CYCLES), .SYNC_STAGES(SYNC_STAGES)) u_gate (
        .clk(clk_i), .rst(rst_i), .ack_tgl_async(ack_tgl), .snap_async(snap),
        .req_tgl(req_tgl), .issue(issue), .meas(meas)
    );

    fmon_idle #(.SYNC_STAGES(SYNC_STAGES)) u_idle (
        .clk(clk_i), .rst(rst_i), .act_async(act_tgl),
        .limit(idle_limit_i), .starved(starved)
    );

    fmon_judge u_judge (
        .clk(clk_i), .rst(rst_i), .meas(meas), .issue(issue), .starved(starved),
        .nominal(nominal_i), .raise_lim(raise_lim_i), .lower_lim(lower_lim_i),
        .los(los_o), .oof(oof_o), .eval_evt(eval_evt), .gap(gap)
    );
endmodule

// File: rtl/fmon_checker.sv
module fmon_checker
    import fmon_pkg::*;
(
    input logic   clk,
    input logic   rst,
    input logic   los,
    input logic   oof,
    input logic   done,
    input logic   starved,
    input logic   eval_evt,
    input count_t gap,
    input count_t raise_lim,
    input count_t lower_lim
);
    assert_los_after_idle_R2: assert property (@(posedge clk) disable iff (rst)
        starved |=> los);

    assert_raise_R4: assert property (@(posedge clk) disable iff (rst)
        (eval_evt && gap >= raise_lim) |=> oof);

    assert_lower_R5: assert property (@(posedge clk) disable iff (rst)
        (eval_evt && gap <= lower_lim && gap < raise_lim) |=> !oof);

    assert_band_hold_R6: assert property (@(posedge clk) disable iff (rst)
        (eval_evt && gap > lower_lim && gap < raise_lim) |=> (oof == $past(oof)));

    // R1 and R7: loss of signal only ends on an accepted measurement
    assert_los_clear_needs_eval_R7: assert property (@(posedge clk) disable iff (rst)
        $fell(los) |-> $past(eval_evt));

    assert_change_only_on_event_R9: assert property (@(posedge clk) disable iff (rst)
        (!$past(done) && !$past(starved)) |-> ($stable(oof) && $stable(los)));
endmodule

bind freq_mon fmon_checker u_fmon_checker (
    .clk(clk_i), .rst(rst_i), .los(los_o), .oof(oof_o), .done(meas.done),
    .starved(starved), .eval_evt(eval_evt), .gap(gap),
    .raise_lim(raise_lim_i), .lower_lim(lower_lim_i)
);

// File: tb/freq_mon_bench.sv
`timescale 1ns/1ps
module freq_mon_bench;
    localparam int  GATE   = 1000;
    localparam real LCLK   = 8.0;
    localparam int  NOM    = 800;
    localparam int  RAISE  = 20;
    localparam int  LOWER  = 10;
    localparam int  IDLE   = 64;
    localparam int  HOLD   = 150;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        mon_clk = 1'b0;
    logic [15:0] nominal = 16'(NOM);
    logic [15:0] raise_lim = 16'(RAISE);
    logic [15:0] lower_lim = 16'(LOWER);
    logic [15:0] idle_limit = 16'(IDLE);
    logic        los;
    logic        oof;

    real   mon_period = 10.0;
    bit    mon_run = 1'b1;
    int    cyc = 0;
    int    total = 0;
    int    bad = 0;
    int    hold_off = 0;
    int    exp_los = 1;
    int    exp_oof = 1;   // -1 means not determined
    int    skip_cnt = 1;
    bit    dead = 1'b0;
    bit    finished = 1'b0;
    string cur_req = "R1";
    real   win_t0 [0:63];
    real   win_t1 [0:63];

    freq_mon u_freq_mon (
        .clk_i(clk), .rst_i(rst), .mon_clk_i(mon_clk),
        .nominal_i(nominal), .raise_lim_i(raise_lim), .lower_lim_i(lower_lim),
        .idle_limit_i(idle_limit), .los_o(los), .oof_o(oof)
    );

    always #4 clk = ~clk;

    always begin
        if (mon_run) begin
            #(mon_period / 2.0) mon_clk = 1'b1;
            #(mon_period / 2.0) mon_clk = 1'b0;
        end else begin
            #1;
        end
    end

    always @(posedge clk) if (!rst) cyc <= cyc + 1;

    function automatic real dev_of(real period);
        real c;
        c = real'(GATE) * LCLK / period;
        return (c >= real'(NOM)) ? c - real'(NOM) : real'(NOM) - c;
    endfunction

    function automatic int decide(real d, int st);
        if (d >= real'(RAISE)) return 1;
        if (d <= real'(LOWER)) return 0;
        return st;
    endfunction

    task automatic check(input int got, input int want, input string what);
        total++;
        if (got != want) begin
            bad++;
            $display("FAIL %s/R9 %s: actual=%0d expected=%0d cycle=%0d", cur_req, what, got, want, cyc);
        end
    endtask

    // Reference model, evaluated away from the active edge
    always @(negedge clk) begin
        if (rst) begin
            check(int'(los), 1, "R1 los during reset");
            check(int'(oof), 1, "R1 oof during reset");
        end else if (!finished) begin
            int ph;
            int w;
            ph = cyc % GATE;
            w  = cyc / GATE;
            if (ph == 1 && w < 64) begin
                win_t0[w] = mon_period;
                win_t1[w] = mon_period;
            end
            if (ph == 15 && w >= 1 && !dead) begin
                if (skip_cnt > 0) skip_cnt--;
                else begin
                    int r0;
                    int r1;
                    r0 = decide(dev_of(win_t0[w-1]), exp_oof);
                    r1 = decide(dev_of(win_t1[w-1]), exp_oof);
                    exp_oof = (r0 == r1) ? r0 : -1;
                    exp_los = 0;
                end
            end
            if (hold_off > 0) hold_off--;
            else if (ph >= 20 && ph <= GATE - 4) begin
                check(int'(los), exp_los, "los");
                if (exp_oof >= 0) check(int'(oof), exp_oof, "oof");
                if (los) check(int'(oof), 1, "R3 oof forced by los");
            end
        end
    end

    task automatic go_to(input int w, input int ph);
        while (cyc != w * GATE + ph) @(negedge clk);
    endtask

    task automatic set_period(input real p, input string tag);
        win_t1[cyc / GATE] = p;
        mon_period = p;
        hold_off = HOLD;
        cur_req = tag;
    endtask

    initial begin
        repeat (5) @(negedge clk);
        rst = 1'b0;
        go_to(3, 40);  set_period(10.191, "R6");  // band entered from below
        go_to(6, 40);  set_period(10.39,  "R4");  // slow by 30 counts
        go_to(9, 40);  set_period(10.191, "R6");  // band entered from above
        go_to(12, 40); set_period(10.063, "R5");  // within lower limit
        go_to(15, 40); set_period(9.639,  "R8");  // fast by 30 counts
        go_to(18, 40); set_period(10.0,   "R5");
        go_to(20, 500);
        cur_req = "R2";                            // short pause below idle limit
        mon_run = 1'b0;
        #160;
        mon_run = 1'b1;
        go_to(22, 40);
        cur_req = "R2";
        mon_run = 1'b0;
        dead = 1'b1;
        exp_los = 1;
        exp_oof = 1;
        hold_off = HOLD;
        go_to(23, 0);  cur_req = "R3";
        go_to(26, 40);
        cur_req = "R7";
        mon_run = 1'b1;
        dead = 1'b0;
        skip_cnt = 1;
        hold_off = HOLD;
        go_to(31, 500);
        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #2_000_000;
        bad++;
        total++;
        $display("FAIL watchdog R1: actual=timeout expected=completion");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule